// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host side of a link to an 8-bit, two-channel serial analog-to-digital converter. The converter shares one bidirectional data wire with the host. A one-cycle request on `start_i` carries a two-bit channel selector. The controller then does the following in order:

- pulls the active-low chip select down;
- runs a serial clock derived from the system clock;
- drives a start bit, the two address bits and two dummy bits;
- releases the wire before the converter takes it over;
- discards the two null bits the converter sends first;
- shifts in the 8-bit result, most significant bit first.

Between conversions, chip select stays high and the serial clock stays low, so the converter's automatic power-down takes effect. A finished conversion is reported by a one-cycle `valid_o` pulse. The result is held on `result_o` until the next conversion completes.

Each transfer lasts 15 serial clock periods. The first five are command periods driven by the host. The next two are null periods and the last eight carry the result. The result code is straight unipolar binary: 0x00 means 0 V and 0xFF means full scale minus one LSB. The controller passes the code through unchanged.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, and whenever `rst_ni` is low, the outputs are `cs_no`=1, `sclk_o`=0, `sdata_oe_o`=0, `valid_o`=0 and `busy_o`=0, and `result_o` is 0x00.
- R2: While idle, a high `start_i` pulls `cs_no` low on the next clock edge and sets `busy_o`. A `start_i` seen while a transfer is running has no effect: it neither changes the running command nor causes a second transfer.
- R3: `sclk_o` is low whenever `cs_no` is high. During a transfer, each SCLK half period is `HALF_DIV` system clocks long. Exactly 15 SCLK periods occur, so `cs_no` stays low for 30·`HALF_DIV` clocks.
- R4: The host drives five command bits on `sdata_o`, changing them only while SCLK is low. In SCLK period 0 it drives the start bit 1. Period 1 carries `chan_i[1]` (single-ended/differential select) and period 2 carries `chan_i[0]` (channel/sign select). Periods 3 and 4 carry dummy bits, driven as 0.
- R5: `sdata_oe_o` rises together with the fall of `cs_no`. It falls while SCLK is high in period 4: one system clock after the fifth rising edge, and before the fifth falling edge that follows the start bit. It stays low until the transfer ends, so host and converter never drive the wire at the same time.
- R6: The host samples `sdata_i` at the rising SCLK edges of periods 7 to 14. It ignores the null bits of periods 5 and 6. The first sampled bit is the MSB of the result.
- R7: At the falling edge that ends period 14, `cs_no` returns high and `valid_o` is high for exactly one clock. `result_o` then holds its value until the next `valid_o`.
- R8: The channel is latched when the request is accepted. Changes on `chan_i` during the transfer do not alter the address bits that are shifted out.
- R9: The result is straight binary with no offset or inversion. Both extreme codes, 0x00 and 0xFF, are returned as received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| chan_i | input | 2 | Channel selector: [1] single-ended/differential, [0] channel/sign |
| busy_o | output | 1 | Transfer in progress |
| result_o | output | RES_W | Last conversion result |
| valid_o | output | 1 | One-cycle pulse when `result_o` is updated |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_o | output | 1 | Data driven onto the shared wire |
| sdata_oe_o | output | 1 | Output enable for the shared wire |
| sdata_i | input | 1 | Value read back from the shared wire |

## Verification
The bench builds the block with `HALF_DIV`=3 and `RES_W`=8. An odd divider makes the high and low SCLK halves last three system clocks each. This gives room to see the data-pin release land strictly between the fifth rising edge and the following falling edge, and to count exact period lengths. A converter model on the shared wire takes the line at the fifth falling edge and updates its data one half system clock after each rising edge. This exposes any host that samples a period early or late, or that is still driving when the model takes over.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int ADDR_W   = 2;  // diff/single select, then channel/sign
  localparam int CMD_LEN  = 5;  // start + address + two dummy
  localparam int NULL_LEN = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } host_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o,
  output logic hi_head_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] ph_q;
  logic             sclk_q;
  logic             ph_last;

  assign ph_last = (ph_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (ph_last) begin
      ph_q   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign sclk_o    = sclk_q;
  assign rise_o    = run_i & ~sclk_q & ph_last;
  assign fall_o    = run_i &  sclk_q & ph_last;
  assign hi_head_o = run_i &  sclk_q & (ph_q == '0);
endmodule

// File: rtl/adc_cmd_tx.sv
module adc_cmd_tx
  import adc_host_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              release_i,
  input  logic              clear_i,
  output logic              sdata_o,
  output logic              oe_o
);
  localparam int DUMMY_LEN = CMD_LEN - 1 - ADDR_W;

  logic [CMD_LEN-1:0] cmd_q;
  logic [CMD_LEN-1:0] cmd_sh;
  logic               oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      oe_q  <= 1'b0;
    end else if (load_i) begin
      cmd_q <= {1'b1, chan_i, {DUMMY_LEN{1'b0}}};
      oe_q  <= 1'b1;
    end else if (release_i || clear_i) begin
      oe_q <= 1'b0;
    end
  end

  // bit for the current period; shifts past the word yield 0
  assign cmd_sh  = cmd_q << idx_i;
  assign sdata_o = oe_q & cmd_sh[CMD_LEN-1];
  assign oe_o    = oe_q;
endmodule

// File: rtl/adc_res_rx.sv
module adc_res_rx #(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             sdata_i,
  output logic [RES_W-1:0] data_o
);
  logic [RES_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[RES_W-2:0], sdata_i};
  end

  assign data_o = sh_q;
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int RES_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] chan_i,
  output logic              busy_o,
  output logic [RES_W-1:0]  result_o,
  output logic              valid_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  input  logic              sdata_i
);
  localparam int NUM_SCLK  = CMD_LEN + NULL_LEN + RES_W;
  localparam int IDX_W     = $clog2(NUM_SCLK);
  localparam int FIRST_RES = CMD_LEN + NULL_LEN;

  host_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic [RES_W-1:0] result_q;
  logic [RES_W-1:0] shreg;
  logic             run, rise, fall, hi_head;
  logic             accept, done, release_pin, shift_in;

  assign run         = (state_q == ST_XFER);
  assign accept      = (state_q == ST_IDLE) & start_i;
  assign done        = fall & (idx_q == IDX_W'(NUM_SCLK - 1));
  // release in the high half of the last command period
  assign release_pin = hi_head & (idx_q == IDX_W'(CMD_LEN - 1));
  assign shift_in    = rise & (idx_q >= IDX_W'(FIRST_RES));

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .sclk_o    (sclk_o),
    .rise_o    (rise),
    .fall_o    (fall),
    .hi_head_o (hi_head)
  );

  adc_cmd_tx #(.IDX_W(IDX_W)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .chan_i    (chan_i),
    .idx_i     (idx_q),
    .release_i (release_pin),
    .clear_i   (done),
    .sdata_o   (sdata_o),
    .oe_o      (sdata_oe_o)
  );

  adc_res_rx #(.RES_W(RES_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_in),
    .sdata_i (sdata_i),
    .data_o  (shreg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        state_q <= ST_XFER;
        idx_q   <= '0;
      end else if (done) begin
        state_q  <= ST_IDLE;
        valid_q  <= 1'b1;
        result_q <= shreg;
      end else if (fall) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o   = run;
  assign cs_no    = ~run;
  assign valid_o  = valid_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
  parameter int RES_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [RES_W-1:0] result_o,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             sdata_o,
  input logic             sdata_oe_o
);
  // R2
  start_takes_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> !cs_no);

  // R3
  idle_sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R4
  data_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // R5
  oe_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> !cs_no);

  // R5
  oe_release_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdata_oe_o) |-> sclk_o);

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  cs_rise_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> valid_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

bind adc_serial_host adc_serial_host_chk #(.RES_W(RES_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o)
);

// File: tb/adc_serial_host_tb.sv
`timescale 1ns/1ps
module adc_serial_host_tb;
  localparam int HALF_DIV = 3;
  localparam int RES_W    = 8;

  // {chan[1:0], result[7:0]}
  localparam logic [9:0] VEC [0:5] = '{
    {2'b10, 8'h00}, {2'b11, 8'hFF}, {2'b00, 8'hA5},
    {2'b01, 8'h5A}, {2'b10, 8'h01}, {2'b11, 8'h80}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] chan_i = 2'b00;
  logic busy_o, valid_o, cs_no, sclk_o, sdata_o, sdata_oe_o;
  logic [RES_W-1:0] result_o;
  wire  sdata_bus;

  int n_chk = 0, n_fail = 0;

  // converter model state
  logic [7:0] model_res = 8'h00;
  logic model_drive = 1'b0, model_bit = 1'b0, conflict = 1'b0;
  logic [4:0] cmd_cap = '0;
  int rise_cnt = 0, fall_cnt = 0, cs_low_cnt = 0, sclk_hi_cnt = 0, oe_falls = 0;
  logic oe_fall_ok = 1'b0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0, oe_prev = 1'b0;

  assign sdata_bus = sdata_oe_o ? sdata_o : (model_drive ? model_bit : 1'b1);

  always #10 clk_i = ~clk_i;

  adc_serial_host #(.HALF_DIV(HALF_DIV), .RES_W(RES_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chan_i(chan_i),
    .busy_o(busy_o), .result_o(result_o), .valid_o(valid_o), .cs_no(cs_no),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sdata_i(sdata_bus)
  );

  always @(negedge clk_i) begin
    if (!cs_no && cs_prev) begin
      rise_cnt = 0; fall_cnt = 0; cmd_cap = '0; model_drive = 0; conflict = 0;
      cs_low_cnt = 0; sclk_hi_cnt = 0; oe_falls = 0; oe_fall_ok = 0;
    end
    if (!cs_no) cs_low_cnt++;
    if (!cs_no && sclk_o) sclk_hi_cnt++;
    if (sclk_o && !sclk_prev) begin
      if (rise_cnt < 5) cmd_cap[4-rise_cnt] = sdata_bus;
      rise_cnt++;
      if (rise_cnt == 6) model_bit = 1'b0;
      else if (rise_cnt >= 7 && rise_cnt <= 14) model_bit = model_res[14-rise_cnt];
    end
    if (!sclk_o && sclk_prev && !cs_no) begin
      fall_cnt++;
      if (fall_cnt == 5) begin model_drive = 1'b1; model_bit = 1'b0; end
    end
    if (oe_prev && !sdata_oe_o) begin
      oe_falls++;
      oe_fall_ok = sclk_o && (rise_cnt == 5) && (fall_cnt == 4);
    end
    if (model_drive && sdata_oe_o) conflict = 1'b1;
    if (cs_no) model_drive = 1'b0;
    cs_prev = cs_no; sclk_prev = sclk_o; oe_prev = sdata_oe_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!valid_o && n < 2000) begin @(negedge clk_i); n++; end
    chk(valid_o, "R7 valid timeout", 32'(valid_o), 1);
  endtask

  task automatic run_xfer(input logic [1:0] ch, input logic [7:0] res, input bit poke);
    model_res = res;
    @(negedge clk_i); chan_i = ch; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; chan_i = ~ch;
    chk(!cs_no && busy_o, "R2 cs low after start", {cs_no, busy_o}, 2'b01);
    if (poke) begin
      repeat (30) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    wait_valid();
    // R6 R9: straight binary result, MSB first
    chk(result_o == res, "R6/R9 result", 32'(result_o), 32'(res));
    // R4 R8: start bit and latched channel
    chk(cmd_cap[4:2] == {1'b1, ch}, "R4/R8 command bits", 32'(cmd_cap), 32'({1'b1, ch, 2'b00}));
    chk(cmd_cap[1:0] == 2'b00, "R4 dummy bits", 32'(cmd_cap[1:0]), 0);
    // R3 period counts
    chk(rise_cnt == 15, "R3 sclk periods", 32'(rise_cnt), 15);
    chk(cs_low_cnt == 30*HALF_DIV, "R3 cs low length", 32'(cs_low_cnt), 32'(30*HALF_DIV));
    chk(sclk_hi_cnt == 15*HALF_DIV, "R3 sclk high length", 32'(sclk_hi_cnt), 32'(15*HALF_DIV));
    // R5 turnaround
    chk(oe_falls == 1 && oe_fall_ok, "R5 release point", {oe_falls[7:0], 7'd0, oe_fall_ok}, 32'h101);
    chk(!conflict, "R5 no bus conflict", 32'(conflict), 0);
    chk(cs_no && !sclk_o, "R7 cs high at end", {cs_no, sclk_o}, 2'b10);
    @(negedge clk_i);
    chk(!valid_o, "R7 valid one cycle", 32'(valid_o), 0);
    chk(result_o == res, "R7 result held", 32'(result_o), 32'(res));
  endtask

  initial begin
    repeat (300000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cs_no && !sclk_o && !sdata_oe_o && !valid_o && !busy_o && result_o == 0,
        "R1 reset outputs", {cs_no, sclk_o, sdata_oe_o, valid_o, busy_o, result_o},
        {5'b10000, 8'h00});
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cs_no && !sclk_o, "R3 idle lines", {cs_no, sclk_o}, 2'b10);

    for (int i = 0; i < 6; i++) run_xfer(VEC[i][9:8], VEC[i][7:0], 1'b0);

    // R2: request during transfer ignored
    run_xfer(2'b01, 8'h3C, 1'b1);
    begin
      int lows = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk_i);
        if (!cs_no) lows++;
      end
      chk(lows == 0, "R2 no second transfer", 32'(lows), 0);
      chk(result_o == 8'h3C, "R7 result held while idle", 32'(result_o), 32'h3C);
    end

    // R1: reset during transfer
    model_res = 8'hC3;
    @(negedge clk_i); chan_i = 2'b11; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(cs_no && !sclk_o && !sdata_oe_o && !busy_o && result_o == 0,
        "R1 reset mid transfer", {cs_no, sclk_o, sdata_oe_o, busy_o, result_o},
        {4'b1000, 8'h00});
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_xfer(2'b00, 8'h7E, 1'b0);

    summary();
    $finish;
  end
endmodule